// File: doc/BRIEF.md
# One-Shot Indexed Configuration Port

This block is a small configuration register file that sits behind a pair of I/O addresses: an index port and a data port. Software first writes a register number to the index port. It then makes exactly one read or write on the data port, and that access reaches the chosen register. After that one access the selection is spent. Touching the same register again takes a new index write.

The block watches a simple single-cycle I/O bus made of an address, a read strobe, a write strobe, write data and read data. For every cycle it raises a claim output that tells the surrounding fabric whether it answered the cycle itself. An unclaimed cycle goes off-chip as an external I/O cycle. The unclaimed cases are:
- any read of the index port;
- a data-port access that has no fresh valid index;
- an index value outside the block's own window;
- any other address.

Only index values inside a parameterised window (by default 50h to 5Fh) select a register.

Top module: `idxcfg_port`

## Requirements
- R1: A write to the index port (address 0022h) is claimed. If its data lies in [IDX_BASE, IDX_BASE+NUM_REGS), it selects register (data − IDX_BASE) for the next data-port access.
- R2: A data-port (address 0023h) write with a valid selection is claimed and updates only the selected register.
- R3: Any data-port read or write clears the selection in the same clock edge. A second data access without a new index write is not claimed and changes no register.
- R4: A read of the index port is never claimed, returns zero on read data, and leaves the current selection unchanged.
- R5: An index write whose value lies outside the window leaves the selection invalid, so the following data access is not claimed.
- R6: An index write made while an earlier selection is still unused replaces that selection and does not count as a data access.
- R7: After reset the selection is invalid and every register reads back as zero.
- R8: A claimed data-port read drives the selected register's value on read data in the same cycle. Every unclaimed cycle drives read data to zero.
- R9: Cycles to any other address, including addresses that match the ports only in their low bits, are not claimed and change no state.
- R10: A cycle with both strobes high is ignored. It is not claimed and changes neither the selection nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W (16) | I/O cycle address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | DATA_W (8) | Write data |
| io_rdata | output | DATA_W (8) | Read data, valid in the cycle of a claimed read |
| io_claim | output | 1 | High when the cycle is answered internally, low when it must go off-chip |

## Verification
The bench targets four weak points:
- Back-to-back data accesses after a single index write. A design that keeps the selection would claim the second access and corrupt or leak a register.
- Index-port reads placed between an index write and its data access. A design that answers them locally, or lets them consume the selection, shows up here.
- Index values just outside the window at both ends. An off-by-one range check would claim a register that does not exist.
- Chained index writes. They catch a design that treats a re-selection as a data access. Aliased addresses and two-strobe cycles are mixed in as well, so an incomplete address compare or a write that wins over an ignored cycle also shows.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

    // Classification of one bus cycle as seen by the port
    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_IDX_WR = 3'd1,
        CMD_IDX_RD = 3'd2,
        CMD_DAT_WR = 3'd3,
        CMD_DAT_RD = 3'd4,
        CMD_OTHER  = 3'd5
    } bus_cmd_e;

    function automatic logic is_data_cmd(input bus_cmd_e c);
        return (c == CMD_DAT_WR) || (c == CMD_DAT_RD);
    endfunction

endpackage

// File: rtl/idxcfg_decode.sv
module idxcfg_decode
    import idxcfg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_PORT  = 'h22,
    parameter int DATA_PORT = 'h23
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_cmd_e          cmd
);

    localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(IDX_PORT);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_PORT);

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = (addr == IDX_A);
        hit_dat = (addr == DAT_A);
        cmd     = CMD_IDLE;
        if (rd && wr) begin
            cmd = CMD_IDLE;             // conflicting strobes: ignored
        end else if (rd || wr) begin
            if (hit_idx) begin
                cmd = wr ? CMD_IDX_WR : CMD_IDX_RD;
            end else if (hit_dat) begin
                cmd = wr ? CMD_DAT_WR : CMD_DAT_RD;
            end else begin
                cmd = CMD_OTHER;
            end
        end
    end

endmodule

// File: rtl/idxcfg_index.sv
module idxcfg_index
    import idxcfg_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IDX_BASE = 'h50,
    parameter int NUM_REGS = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_e          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic              sel_valid,
    output logic [SEL_W-1:0]  sel
);

    localparam logic [DATA_W:0] LO_X = (DATA_W+1)'(IDX_BASE);
    localparam logic [DATA_W:0] HI_X = (DATA_W+1)'(IDX_BASE + NUM_REGS);

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
    } idx_state_t;

    idx_state_t st_d, st_q;
    logic       in_range;

    always_comb begin
        st_d     = st_q;
        in_range = ({1'b0, wdata} >= LO_X) && ({1'b0, wdata} < HI_X);
        if (cmd == CMD_IDX_WR) begin
            st_d.valid = in_range;
            st_d.sel   = in_range ? SEL_W'(wdata - DATA_W'(IDX_BASE)) : '0;
        end else if (is_data_cmd(cmd)) begin
            st_d.valid = 1'b0;          // one access consumes the selection
            st_d.sel   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_valid = st_q.valid;
    assign sel       = st_q.sel;

    AST_DATA_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        is_data_cmd(cmd) |=> !sel_valid) else $error("selection survived data access"); // R3

    AST_OOR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDX_WR && (wdata < DATA_W'(IDX_BASE))) |=> !sel_valid)
        else $error("low out-of-range index latched"); // R5

    AST_IDX_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDX_RD) |=> ($stable(sel_valid) && $stable(sel)))
        else $error("index read disturbed selection"); // R4

endmodule

// File: rtl/idxcfg_regs.sv
module idxcfg_regs #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (sel == SEL_W'(i))) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = regs_q[sel];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(sel)] == $past(wdata)))
        else $error("register write lost"); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)) else $error("register changed without write"); // R9

endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
    import idxcfg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int IDX_PORT  = 'h22,
    parameter int DATA_PORT = 'h23,
    parameter int IDX_BASE  = 'h50,
    parameter int NUM_REGS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_claim
);

    localparam int SEL_W = $clog2(NUM_REGS);

    bus_cmd_e          cmd;
    logic              sel_valid;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] reg_val;
    logic              reg_wr;
    logic              rd_claim;

    idxcfg_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_PORT (IDX_PORT),
        .DATA_PORT(DATA_PORT)
    ) u_decode (
        .addr(io_addr),
        .rd  (io_rd),
        .wr  (io_wr),
        .cmd (cmd)
    );

    idxcfg_index #(
        .DATA_W  (DATA_W),
        .IDX_BASE(IDX_BASE),
        .NUM_REGS(NUM_REGS)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wdata    (io_wdata),
        .sel_valid(sel_valid),
        .sel      (sel)
    );

    idxcfg_regs #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(reg_wr),
        .sel  (sel),
        .wdata(io_wdata),
        .rdata(reg_val)
    );

    always_comb begin
        reg_wr   = (cmd == CMD_DAT_WR) && sel_valid;
        rd_claim = (cmd == CMD_DAT_RD) && sel_valid;
        io_claim = (cmd == CMD_IDX_WR) || reg_wr || rd_claim;
        io_rdata = rd_claim ? reg_val : '0;
    end

    AST_IDX_RD_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_IDX_RD) |-> !io_claim) else $error("index read claimed"); // R4

    AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !io_claim |-> (io_rdata == '0)) else $error("data driven while forwarding"); // R8

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_data_cmd(cmd) && $past(is_data_cmd(cmd))) |-> !io_claim)
        else $error("second data access claimed"); // R3

    AST_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_wr) |-> !io_claim) else $error("dual-strobe cycle claimed"); // R10

endmodule

// File: tb/idxcfg_port_bench.sv
module idxcfg_port_bench;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] io_addr = '0;
    logic              io_rd = 1'b0;
    logic              io_wr = 1'b0;
    logic [DATA_W-1:0] io_wdata = '0;
    logic [DATA_W-1:0] io_rdata;
    logic              io_claim;

    int compared = 0;
    int mismatched = 0;

    // behavioural reference state
    int  m_regs [16];
    bit  m_valid;
    int  m_idx;

    always #2 clk = ~clk;   // 250 MHz

    idxcfg_port u_idxcfg_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .io_claim(io_claim)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, compare before posedge, update model after
    task automatic cyc(input int addr, input bit rd, input bit wr, input int wd, input string tag);
        bit is_i, is_d, exp_claim;
        int exp_rdata;
        @(negedge clk);
        io_addr  = ADDR_W'(addr);
        io_rd    = rd;
        io_wr    = wr;
        io_wdata = DATA_W'(wd);
        #1;
        is_i = (addr == 'h22);
        is_d = (addr == 'h23);
        exp_claim = !(rd && wr) && ((is_i && wr) || (is_d && (rd || wr) && m_valid));
        exp_rdata = (exp_claim && is_d && rd) ? m_regs[m_idx] : 0;
        check(int'(io_claim), int'(exp_claim), tag, "claim");
        check(int'(io_rdata), exp_rdata, tag, "rdata");
        @(posedge clk);
        if (!(rd && wr)) begin
            if (is_i && wr) begin
                m_valid = (wd >= 'h50) && (wd < 'h60);
                m_idx   = m_valid ? wd - 'h50 : 0;
            end else if (is_d && (rd || wr)) begin
                if (m_valid && wr) m_regs[m_idx] = wd;
                m_valid = 1'b0;
                m_idx   = 0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        foreach (m_regs[i]) m_regs[i] = 0;
        m_valid = 1'b0;
        m_idx   = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: no selection after reset, all registers zero
        cyc('h23, 1, 0, 0, "R7");
        for (int i = 0; i < 16; i++) begin
            cyc('h22, 0, 1, 'h50 + i, "R7");
            cyc('h23, 1, 0, 0, "R7");
        end

        // R1 R2 R8: write then read back
        cyc('h22, 0, 1, 'h53, "R1");
        cyc('h23, 0, 1, 'hA5, "R2");
        cyc('h22, 0, 1, 'h53, "R1");
        @(negedge clk);
        io_addr = 16'h0023; io_rd = 1'b1; io_wr = 1'b0;
        #1;
        check(int'(io_rdata), 'hA5, "R8", "literal readback");
        check(int'(io_claim), 1, "R8", "literal claim");
        io_rd = 1'b0;
        io_addr = 16'h0000;
        @(posedge clk);
        m_valid = 1'b0;
        // R2: neighbours untouched
        cyc('h22, 0, 1, 'h52, "R2");
        cyc('h23, 1, 0, 0, "R2");
        cyc('h22, 0, 1, 'h54, "R2");
        cyc('h23, 1, 0, 0, "R2");

        // R3: repeated data access without new index
        cyc('h22, 0, 1, 'h5F, "R3");
        cyc('h23, 0, 1, 'h3C, "R3");
        cyc('h23, 0, 1, 'hFF, "R3");
        cyc('h23, 1, 0, 0, "R3");
        cyc('h22, 0, 1, 'h5F, "R3");
        cyc('h23, 1, 0, 0, "R3");

        // R4: index-port read forwarded, selection preserved
        cyc('h22, 0, 1, 'h53, "R4");
        cyc('h22, 1, 0, 0, "R4");
        cyc('h22, 1, 0, 0, "R4");
        cyc('h23, 1, 0, 0, "R4");

        // R5: out-of-range index at both edges
        cyc('h22, 0, 1, 'h4F, "R5");
        cyc('h23, 0, 1, 'h11, "R5");
        cyc('h22, 0, 1, 'h60, "R5");
        cyc('h23, 1, 0, 0, "R5");
        cyc('h22, 0, 1, 'h53, "R5");
        cyc('h22, 0, 1, 'h60, "R5");
        cyc('h23, 1, 0, 0, "R5");

        // R6: consecutive index writes
        cyc('h22, 0, 1, 'h51, "R6");
        cyc('h22, 0, 1, 'h57, "R6");
        cyc('h23, 0, 1, 'h77, "R6");
        cyc('h22, 0, 1, 'h51, "R6");
        cyc('h23, 1, 0, 0, "R6");
        cyc('h22, 0, 1, 'h57, "R6");
        cyc('h23, 1, 0, 0, "R6");

        // R9: other and aliased addresses
        cyc('h22, 0, 1, 'h57, "R9");
        cyc('h0123, 0, 1, 'h99, "R9");
        cyc('h0122, 0, 1, 'h50, "R9");
        cyc('h24, 1, 0, 0, "R9");
        cyc('h23, 1, 0, 0, "R9");

        // R10: both strobes together
        cyc('h22, 0, 1, 'h57, "R10");
        cyc('h23, 1, 1, 'hEE, "R10");
        cyc('h22, 1, 1, 'h50, "R10");
        cyc('h23, 1, 0, 0, "R10");

        // mixed traffic against the reference model
        for (int n = 0; n < 3000; n++) begin
            int sel_a, a, wd;
            bit rd, wr;
            sel_a = $urandom_range(0, 9);
            a  = (sel_a < 4) ? 'h22 : (sel_a < 8) ? 'h23 : (sel_a == 8) ? 'h0122 : 'h21;
            wd = ($urandom_range(0, 3) != 0) ? $urandom_range('h4E, 'h61) : $urandom_range(0, 255);
            case ($urandom_range(0, 9))
                0:       begin rd = 1; wr = 1; end
                1, 2, 3: begin rd = 1; wr = 0; end
                4:       begin rd = 0; wr = 0; end
                default: begin rd = 0; wr = 1; end
            endcase
            cyc(a, rd, wr, wd, "R1-mix");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule